// File: doc/BRIEF.md
# Flash Command and Status Controller

This block models the control logic of a small parallel NOR flash device. A host reaches it over a simple asynchronous-style bus made of chip enable, write enable, output enable, an address and an 8-bit data path. Each bus write goes to a command decoder. An unlock sequence followed by a command byte starts one of two self-timed algorithms on a small on-chip array. One programs a single byte. The other erases one sector, and before it erases, it programs to 0x00 every byte of that sector that is not already 0x00.

While an algorithm runs, host reads return a status byte instead of array data. Bit 7 is a data-polling bit and bit 6 changes on every read. Once the algorithm ends, reads return array contents again. Each sector has its own protection input. A low-supply detect input blocks every bus write. With chip enable high the block is in standby: its outputs are released and any running algorithm continues. Pulse timing is replaced by fixed cycle counts.

All bus inputs are sampled on `clk`. A write is taken on the first clock edge at which chip enable and write enable are both low after write enable was high. A read starts on the first edge at which chip enable and output enable are low, write enable is high, and output enable was high before. The host address splits into a sector index, taken from the top `SEC_W` bits, and a byte offset, taken from the low `OFF_W` bits.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every array byte reads 0xFF, no algorithm is running, and `dq_oe` is high only while `ce_n` and `oe_n` are low and `we_n` is high.
- R2: The writes 0xAA to 0x5555, 0x55 to 0x2AAA, 0xA0 to 0x5555 and then D to address A set the byte at A to its old value AND D. Bits can only be cleared.
- R3: During a program, reads return bit 7 equal to the inverse of bit 7 of D, with bits 5..0 zero. The algorithm runs `PROG_CYC` cycles and then checks the written cell before it returns to array reads.
- R4: The writes 0xAA to 0x5555, 0x55 to 0x2AAA, 0x80 to 0x5555, 0xAA to 0x5555, 0x55 to 0x2AAA and then 0x30 to any address in sector S set every byte of S to 0xFF and leave all other sectors unchanged.
- R5: An erase first programs to 0x00 each byte of the sector that is not 0x00, taking `PROG_CYC` cycles per such byte, and then erases. While the erase runs, status bit 7 reads 0.
- R6: While an algorithm runs, status bit 6 takes the opposite value on each successive read.
- R7: A program or erase aimed at a sector whose `prot` bit is 1 does not start and changes no byte.
- R8: While `lv_det` is 1, bus writes have no effect, including any effect on the progress of an unlock sequence.
- R9: A write of 0xF0 in any decoder state except the one waiting for program data returns the decoder to read mode. A write that does not match the expected next step of a sequence also returns it to read mode.
- R10: With `ce_n` high, `dq_oe` is 0, and a running algorithm still completes.
- R11: While an algorithm runs, bus writes are ignored, and a command sequence written during that time has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Byte address |
| dq_i | input | 8 | Write data |
| lv_det | input | 1 | Low-supply detect; blocks writes |
| prot | input | 2**SEC_W | Per-sector protection flags |
| dq_o | output | 8 | Read data or status byte |
| dq_oe | output | 1 | Output drive enable for dq_o |

## Verification
The bench compares the time a sector erase takes when the sector holds all 0x00 with the time it takes when the sector is fully 0xFF. A design that skipped pre-programming, or that pre-programmed bytes that were already clear, would make those two times equal or too far apart. Program data of 0xF0 is written so that a decoder which treats it as a reset is caught: that decoder would leave the byte unprogrammed. Command sequences are written while an erase is busy and while `lv_det` is high, and aborted unlocks are tried. A decoder that stayed half-armed would then program a byte the model keeps unchanged. Protected sectors are targeted at random, and each read during an algorithm is compared against the expected poll and toggle bits, so a status path that stalled or showed array data too early is reported.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  typedef enum logic [2:0] {
    DEC_IDLE, DEC_UNL1, DEC_UNL2, DEC_PDATA, DEC_ERS1, DEC_ERS2, DEC_ERS3
  } dec_state_t;

  typedef enum logic [2:0] {
    ENG_IDLE, ENG_PROG, ENG_PRE, ENG_ERASE, ENG_VERIFY
  } eng_state_t;

  localparam logic [7:0] CMD_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CMD_UNLOCK2 = 8'h55;
  localparam logic [7:0] CMD_PROGRAM = 8'hA0;
  localparam logic [7:0] CMD_ERASE   = 8'h80;
  localparam logic [7:0] CMD_SECTOR  = 8'h30;
  localparam logic [7:0] CMD_RESET   = 8'hF0;
  localparam logic [15:0] UNLOCK_ADDR1 = 16'h5555;
  localparam logic [15:0] UNLOCK_ADDR2 = 16'h2AAA;
endpackage

// File: rtl/fcs_cell_array.sv
module fcs_cell_array #(
  parameter int SEC_W = 3,
  parameter int OFF_W = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [SEC_W+OFF_W-1:0]       wr_idx,
  input  logic [7:0]                   wr_mask,
  input  logic                         ers_en,
  input  logic [SEC_W-1:0]             ers_sec,
  input  logic [(1<<SEC_W)-1:0]        prot,
  input  logic [SEC_W+OFF_W-1:0]       host_idx,
  output logic [7:0]                   host_q,
  input  logic [SEC_W+OFF_W-1:0]       eng_idx,
  output logic [7:0]                   eng_q
);
  localparam int IDX_W = SEC_W + OFF_W;
  localparam int NBYTE = 1 << IDX_W;
  localparam int SBYTE = 1 << OFF_W;

  logic [NBYTE*8-1:0] mem_flat;

  for (genvar g = 0; g < NBYTE; g++) begin : g_cell
    localparam int SECG = g / SBYTE;
    logic [7:0] cell_q;
    logic       hit_ers, hit_wr;
    assign hit_ers = ers_en && (ers_sec == SEC_W'(SECG));
    assign hit_wr  = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cell_q <= 8'hFF;
      else if (hit_ers) cell_q <= 8'hFF;
      else if (hit_wr)  cell_q <= cell_q & wr_mask;
    end
    assign mem_flat[g*8 +: 8] = cell_q;
  end

  assign host_q = mem_flat[host_idx*8 +: 8];
  assign eng_q  = mem_flat[eng_idx*8 +: 8];

  assert_prot_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !prot[wr_idx[IDX_W-1 -: SEC_W]]);
  assert_prot_erase_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ers_en |-> !prot[ers_sec]);
endmodule

// File: rtl/fcs_cmd_decoder.sv
module fcs_cmd_decoder
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        data,
  input  logic              busy,
  input  logic              lv_det,
  output logic              start_prog,
  output logic              start_ers
);
  localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNLOCK_ADDR1);
  localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNLOCK_ADDR2);

  dec_state_t st_q, st_d;
  logic       take;

  assign take = wr_stb && !lv_det && !busy;

  always_comb begin
    st_d       = st_q;
    start_prog = 1'b0;
    start_ers  = 1'b0;
    if (take) begin
      st_d = DEC_IDLE;
      if (st_q == DEC_PDATA) begin
        start_prog = 1'b1;
      end else if (data != CMD_RESET) begin
        case (st_q)
          DEC_IDLE: if (data == CMD_UNLOCK1 && addr == A1) st_d = DEC_UNL1;
          DEC_UNL1: if (data == CMD_UNLOCK2 && addr == A2) st_d = DEC_UNL2;
          DEC_UNL2: begin
            if (data == CMD_PROGRAM && addr == A1) st_d = DEC_PDATA;
            else if (data == CMD_ERASE && addr == A1) st_d = DEC_ERS1;
          end
          DEC_ERS1: if (data == CMD_UNLOCK1 && addr == A1) st_d = DEC_ERS2;
          DEC_ERS2: if (data == CMD_UNLOCK2 && addr == A2) st_d = DEC_ERS3;
          DEC_ERS3: start_ers = (data == CMD_SECTOR);
          default:  st_d = DEC_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= DEC_IDLE;
    else        st_q <= st_d;
  end

  assert_lockout_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lv_det && wr_stb) |=> $stable(st_q));
  assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_stb) |=> $stable(st_q));
endmodule

// File: rtl/fcs_algo_engine.sv
module fcs_algo_engine
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int SEC_W     = 3,
  parameter int OFF_W     = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 40
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start_prog,
  input  logic                   start_ers,
  input  logic [ADDR_W-1:0]      cmd_addr,
  input  logic [7:0]             cmd_data,
  input  logic [(1<<SEC_W)-1:0]  prot,
  input  logic [7:0]             eng_q,
  output logic [SEC_W+OFF_W-1:0] eng_idx,
  output logic                   wr_en,
  output logic [7:0]             wr_mask,
  output logic                   ers_en,
  output logic [SEC_W-1:0]       ers_sec,
  output logic                   busy,
  output logic                   poll_bit
);
  localparam int MAXC  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int CNT_W = $clog2(MAXC + 1);
  localparam logic [CNT_W-1:0] PROG_LAST  = CNT_W'(PROG_CYC - 1);
  localparam logic [CNT_W-1:0] ERASE_LAST = CNT_W'(ERASE_CYC - 1);
  localparam logic [OFF_W-1:0] OFF_LAST   = '1;

  eng_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [SEC_W-1:0] sec_q, sec_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic [7:0]       data_q, data_d;
  logic             ers_q, ers_d;
  logic [SEC_W-1:0] cmd_sec;

  assign cmd_sec = cmd_addr[ADDR_W-1 -: SEC_W];

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; sec_d = sec_q; off_d = off_q;
    data_d = data_q; ers_d = ers_q;
    wr_en = 1'b0; ers_en = 1'b0;
    case (st_q)
      ENG_IDLE: begin
        if (start_prog && !prot[cmd_sec]) begin
          st_d = ENG_PROG; cnt_d = '0; sec_d = cmd_sec;
          off_d = cmd_addr[OFF_W-1:0]; data_d = cmd_data; ers_d = 1'b0;
        end else if (start_ers && !prot[cmd_sec]) begin
          st_d = ENG_PRE; cnt_d = '0; sec_d = cmd_sec;
          off_d = '0; data_d = 8'h00; ers_d = 1'b1;
        end
      end
      ENG_PROG: begin
        if (cnt_q == PROG_LAST) begin wr_en = 1'b1; st_d = ENG_VERIFY; end
        else cnt_d = cnt_q + 1'b1;
      end
      ENG_PRE: begin
        if (eng_q == 8'h00) begin
          cnt_d = '0;
          if (off_q == OFF_LAST) st_d = ENG_ERASE;
          else off_d = off_q + 1'b1;
        end else if (cnt_q == PROG_LAST) begin
          wr_en = 1'b1; cnt_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ENG_ERASE: begin
        if (cnt_q == ERASE_LAST) begin
          ers_en = 1'b1; st_d = ENG_VERIFY; off_d = '0;
        end else cnt_d = cnt_q + 1'b1;
      end
      ENG_VERIFY: begin
        if (!ers_q || off_q == OFF_LAST) st_d = ENG_IDLE;
        else off_d = off_q + 1'b1;
      end
      default: st_d = ENG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ENG_IDLE; cnt_q <= '0; sec_q <= '0; off_q <= '0;
      data_q <= 8'h00; ers_q <= 1'b0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; sec_q <= sec_d; off_q <= off_d;
      data_q <= data_d; ers_q <= ers_d;
    end
  end

  assign eng_idx  = {sec_q, off_q};
  assign wr_mask  = data_q;
  assign ers_sec  = sec_q;
  assign busy     = (st_q != ENG_IDLE);
  assign poll_bit = ers_q ? 1'b0 : ~data_q[7];

  assert_verify_prog_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_VERIFY && !ers_q) |-> ((eng_q & ~data_q) == 8'h00));
  assert_verify_erase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_VERIFY && ers_q) |-> (eng_q == 8'hFF));
  assert_preprog_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ENG_PRE && st_d == ENG_ERASE) |-> (eng_q == 8'h00));
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl #(
  parameter int ADDR_W    = 15,
  parameter int SEC_W     = 3,
  parameter int OFF_W     = 2,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 40
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ce_n,
  input  logic                  we_n,
  input  logic                  oe_n,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [7:0]            dq_i,
  input  logic                  lv_det,
  input  logic [(1<<SEC_W)-1:0] prot,
  output logic [7:0]            dq_o,
  output logic                  dq_oe
);
  localparam int IDX_W = SEC_W + OFF_W;

  logic [1:0]       rs_q;
  logic             rst_i;
  logic             we_q, oe_q, tog_q;
  logic             wr_stb, rd_stb;
  logic             start_prog, start_ers, busy, poll_bit;
  logic             wr_en, ers_en;
  logic [7:0]       wr_mask, host_q, eng_q;
  logic [IDX_W-1:0] eng_idx, host_idx;
  logic [SEC_W-1:0] ers_sec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      we_q <= 1'b1; oe_q <= 1'b1; tog_q <= 1'b0;
    end else begin
      we_q <= we_n; oe_q <= oe_n;
      if (rd_stb && busy) tog_q <= ~tog_q;
    end
  end

  assign wr_stb   = !ce_n && !we_n && we_q;
  assign rd_stb   = !ce_n && !oe_n && we_n && oe_q;
  assign host_idx = {addr[ADDR_W-1 -: SEC_W], addr[OFF_W-1:0]};

  fcs_cmd_decoder #(.ADDR_W(ADDR_W)) u_dec (
    .clk(clk), .rst_n(rst_i), .wr_stb(wr_stb), .addr(addr), .data(dq_i),
    .busy(busy), .lv_det(lv_det), .start_prog(start_prog), .start_ers(start_ers));

  fcs_algo_engine #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .OFF_W(OFF_W),
                    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk(clk), .rst_n(rst_i), .start_prog(start_prog), .start_ers(start_ers),
    .cmd_addr(addr), .cmd_data(dq_i), .prot(prot), .eng_q(eng_q),
    .eng_idx(eng_idx), .wr_en(wr_en), .wr_mask(wr_mask), .ers_en(ers_en),
    .ers_sec(ers_sec), .busy(busy), .poll_bit(poll_bit));

  fcs_cell_array #(.SEC_W(SEC_W), .OFF_W(OFF_W)) u_arr (
    .clk(clk), .rst_n(rst_i), .wr_en(wr_en), .wr_idx(eng_idx), .wr_mask(wr_mask),
    .ers_en(ers_en), .ers_sec(ers_sec), .prot(prot), .host_idx(host_idx),
    .host_q(host_q), .eng_idx(eng_idx), .eng_q(eng_q));

  assign dq_oe = !ce_n && !oe_n && we_n;
  assign dq_o  = busy ? {poll_bit, tog_q, 6'b0} : host_q;

  assert_toggle_R6: assert property (@(posedge clk) disable iff (!rst_i)
    (busy && rd_stb) |=> (tog_q != $past(tog_q)));
  assert_start_cause_R11: assert property (@(posedge clk) disable iff (!rst_i)
    $rose(busy) |-> $past(start_prog || start_ers));
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb_top;
  localparam int ADDR_W = 15, SEC_W = 3, OFF_W = 2, PROG_CYC = 16, ERASE_CYC = 40;
  localparam int NSEC = 1 << SEC_W;
  localparam int SB   = 1 << OFF_W;
  localparam int NB   = NSEC * SB;

  logic clk = 1'b0;
  logic rst_n, ce_n, we_n, oe_n, lv_det;
  logic [ADDR_W-1:0] addr;
  logic [7:0] dq_i, dq_o;
  logic [NSEC-1:0] prot;
  logic dq_oe;

  int checks = 0, errors = 0;
  logic [7:0] model [NB];

  always #4 clk = ~clk;

  flash_cmd_ctrl #(.ADDR_W(ADDR_W), .SEC_W(SEC_W), .OFF_W(OFF_W),
                   .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .dq_i(dq_i), .lv_det(lv_det), .prot(prot),
    .dq_o(dq_o), .dq_oe(dq_oe));

  function automatic int idx_of(logic [ADDR_W-1:0] a);
    return int'({a[ADDR_W-1 -: SEC_W], a[OFF_W-1:0]});
  endfunction

  function automatic logic [ADDR_W-1:0] addr_of(int sec, int off);
    logic [ADDR_W-1:0] a;
    a = '0;
    a[ADDR_W-1 -: SEC_W] = SEC_W'(sec);
    a[OFF_W-1:0] = OFF_W'(off);
    return a;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dq_i = d; ce_n = 1'b0; we_n = 1'b0;
    @(negedge clk);
    we_n = 1'b1; ce_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; ce_n = 1'b0; oe_n = 1'b0;
    @(negedge clk);
    d = dq_o;
    check(dq_oe === 1'b1, "R1 dq_oe during read", int'(dq_oe), 1);
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  task automatic seq_prog(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    bus_write(15'h5555, 8'hAA); bus_write(15'h2AAA, 8'h55);
    bus_write(15'h5555, 8'hA0); bus_write(a, d);
  endtask

  task automatic seq_erase(input int sec);
    bus_write(15'h5555, 8'hAA); bus_write(15'h2AAA, 8'h55);
    bus_write(15'h5555, 8'h80); bus_write(15'h5555, 8'hAA);
    bus_write(15'h2AAA, 8'h55); bus_write(addr_of(sec, 1), 8'h30);
  endtask

  task automatic wait_done(input logic [ADDR_W-1:0] a, output int n);
    logic [7:0] prev, cur;
    bus_read(a, prev);
    n = 0;
    while (n < 500) begin
      bus_read(a, cur);
      n++;
      if (cur == prev) break;
      prev = cur;
    end
  endtask

  task automatic check_byte(input logic [ADDR_W-1:0] a, input string req);
    logic [7:0] r;
    bus_read(a, r);
    check(r == model[idx_of(a)], req, int'(r), int'(model[idx_of(a)]));
  endtask

  task automatic do_prog(input logic [ADDR_W-1:0] a, input logic [7:0] d, input bit lv);
    logic [7:0] r1, r2;
    int n;
    bit active;
    active = !prot[idx_of(a) / SB] && !lv;
    lv_det = lv;
    seq_prog(a, d);
    lv_det = 1'b0;
    bus_read(a, r1); bus_read(a, r2);
    if (active) begin
      check(r1[7] == ~d[7] && r1[5:0] == 6'd0, "R3 poll bit during program", int'(r1), int'({~d[7], 7'd0}));
      check(r1[6] != r2[6], "R6 toggle during program", int'(r2[6]), int'(~r1[6]));
      wait_done(a, n);
      model[idx_of(a)] = model[idx_of(a)] & d;
      check_byte(a, "R2 program result");
    end else begin
      check(r1 == model[idx_of(a)] && r2 == r1, lv ? "R8 lockout program" : "R7 protected program",
            int'(r1), int'(model[idx_of(a)]));
    end
  endtask

  task automatic do_erase(input int sec, input bit lv, output int n);
    logic [7:0] r1, r2;
    bit active;
    active = !prot[sec] && !lv;
    lv_det = lv;
    seq_erase(sec);
    lv_det = 1'b0;
    n = 0;
    bus_read(addr_of(sec, 0), r1); bus_read(addr_of(sec, 0), r2);
    if (active) begin
      check(r1[7] == 1'b0 && r2[7] == 1'b0, "R5 poll bit during erase", int'(r1), 0);
      check(r1[6] != r2[6], "R6 toggle during erase", int'(r2[6]), int'(~r1[6]));
      wait_done(addr_of(sec, 0), n);
      for (int k = 0; k < SB; k++) model[sec*SB + k] = 8'hFF;
    end
    for (int k = 0; k < SB; k++)
      check_byte(addr_of(sec, k), active ? "R4 erased sector" : (lv ? "R8 lockout erase" : "R7 protected erase"));
    check_byte(addr_of((sec + 1) % NSEC, 2), "R4 neighbour sector unchanged");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog R1-watch actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] r;
    int n0, n1, nd;
    void'($urandom(32'd9173));
    rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1; lv_det = 1'b0;
    addr = '0; dq_i = 8'h00; prot = '0;
    for (int i = 0; i < NB; i++) model[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state and output enable gating
    check(dq_oe === 1'b0, "R1 dq_oe idle", int'(dq_oe), 0);
    for (int i = 0; i < NB; i += 5) check_byte(addr_of(i / SB, i % SB), "R1 reset content");

    // R2: basic program and AND behaviour, including data 0xF0
    do_prog(addr_of(3, 1), 8'h5A, 1'b0);
    do_prog(addr_of(3, 1), 8'hF0, 1'b0);
    do_prog(addr_of(6, 2), 8'hF0, 1'b0);

    // R9: reset command mid-sequence, and a wrong address aborting
    bus_write(15'h5555, 8'hAA); bus_write(15'h2AAA, 8'h55); bus_write(15'h5555, 8'hF0);
    bus_write(15'h5555, 8'hA0); bus_write(addr_of(4, 0), 8'h12);
    check_byte(addr_of(4, 0), "R9 reset command aborts");
    bus_write(15'h5555, 8'hAA); bus_write(15'h1234, 8'h55);
    bus_write(15'h5555, 8'hA0); bus_write(addr_of(4, 3), 8'h34);
    check_byte(addr_of(4, 3), "R9 bad address aborts");

    // R5: pre-program timing, all-zero sector against all-0xFF sector
    for (int k = 0; k < SB; k++) do_prog(addr_of(1, k), 8'h00, 1'b0);
    do_erase(1, 1'b0, n0);
    do_erase(2, 1'b0, n1);
    nd = n1 - n0;
    check(nd >= (SB * PROG_CYC) / 2 - 2 && nd <= (SB * PROG_CYC) / 2 + 4,
          "R5 pre-program duration", nd, (SB * PROG_CYC) / 2);

    // R11: commands written while busy are ignored
    seq_erase(5);
    seq_prog(addr_of(0, 0), 8'h00);
    wait_done(addr_of(5, 0), n0);
    for (int k = 0; k < SB; k++) model[5*SB + k] = 8'hFF;
    check_byte(addr_of(0, 0), "R11 write while busy ignored");
    check_byte(addr_of(5, 3), "R11 erase finished");

    // R10: standby releases outputs, algorithm keeps running
    do_prog(addr_of(7, 0), 8'h0F, 1'b0);
    seq_erase(7);
    @(negedge clk);
    check(dq_oe === 1'b0, "R10 standby output off", int'(dq_oe), 0);
    repeat (3 * ERASE_CYC + SB * (PROG_CYC + 2)) @(negedge clk);
    check(dq_oe === 1'b0, "R10 standby output off late", int'(dq_oe), 0);
    for (int k = 0; k < SB; k++) model[7*SB + k] = 8'hFF;
    bus_read(addr_of(7, 0), r);
    check(r == 8'hFF, "R10 erase completed in standby", int'(r), 255);

    // R7 / R8 directed
    prot = 8'b0000_1000;
    do_prog(addr_of(3, 2), 8'h00, 1'b0);
    do_erase(3, 1'b0, n0);
    prot = '0;
    do_prog(addr_of(6, 0), 8'h00, 1'b1);
    do_erase(6, 1'b1, n0);

    // Random mix
    for (int it = 0; it < 40; it++) begin
      int op, sec, off;
      bit lv;
      prot = NSEC'($urandom) & NSEC'($urandom);
      op = int'($urandom % 10);
      lv = ($urandom % 10) == 0;
      sec = int'($urandom % NSEC);
      off = int'($urandom % SB);
      if (op < 7) begin
        logic [ADDR_W-1:0] a;
        a = addr_of(sec, off);
        a[ADDR_W-SEC_W-1:OFF_W] = (ADDR_W-SEC_W-OFF_W)'($urandom);
        do_prog(a, 8'($urandom), lv);
      end else begin
        do_erase(sec, lv, n0);
      end
    end
    prot = '0;
    for (int i = 0; i < NB; i++) check_byte(addr_of(i / SB, i % SB), "R2 final array image");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule